// File: doc/BRIEF.md
# Power-Up Strap Capture and Pad Sequencer

This block owns a group of shared pads that carry configuration straps while the supply ramps and clock outputs once the chip is up. As long as the supply-good indication is low, every pad is released (output enable low) so that external pull resistors set its level. When supply-good arrives, the block samples each pad's level once into a configuration word. It then turns the pads into outputs held low. A power-up timer, counted in reference clock cycles, finally lets each pad follow its own clock source.

The sequencer has four named states. WAIT_SUPPLY releases all pads and waits for the synchronized supply-good. LATCH lasts one cycle and captures the straps. DRIVE_LOW enables all outputs at logic 0 and runs the timer. RUN passes the clock sources through. The transitions are: WAIT_SUPPLY to LATCH on synchronized supply-good high. LATCH to DRIVE_LOW unconditionally, unless supply-good has dropped. DRIVE_LOW to RUN when the timer expires. Any state returns to WAIT_SUPPLY when the synchronized supply-good is low.

The configuration word keeps its value outside the LATCH cycle, including after a supply drop, until the next LATCH overwrites it. The default timer length is 150000 cycles, which is 3 ms at a 50 MHz reference.

Top module: `strap_pad_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pad_oe`, `pad_out` and `cfg_word` are all zero.
- R2: While the sequencer is in WAIT_SUPPLY, every bit of `pad_oe` and `pad_out` is 0 (all pads released).
- R3: `supply_good` passes through SYNC_STAGES flip-flops. After it rises, LATCH is entered on edge SYNC_STAGES+1 and lasts exactly one cycle.
- R4: On the edge that ends LATCH, `cfg_word[i]` takes the level of `pad_in[i]`. `pad_oe` is still all 0 during that cycle, so the captured value is the external strap and never the block's own drive.
- R5: From the edge SYNC_STAGES+2 after `supply_good` rises, `pad_oe` is all 1 and `pad_out` is all 0 for exactly TIMER_CYCLES cycles (DRIVE_LOW).
- R6: From the edge SYNC_STAGES+2+TIMER_CYCLES onward (RUN), `pad_oe` stays all 1 and `pad_out[i]` equals `clk_src[i]` for every pin.
- R7: `cfg_word` changes only on the edge that ends LATCH. Strap changes on `pad_in` at any other time have no effect.
- R8: When `supply_good` falls in any state, `pad_oe` and `pad_out` are all 0 from edge SYNC_STAGES+1 onward. The next rise of `supply_good` restarts the sequence with a new capture and a full timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_good | input | 1 | Supply-good indication, asynchronous |
| pad_in | input | NUM_PINS | Level seen on each pad |
| clk_src | input | NUM_PINS | Clock source for each pad in RUN |
| pad_oe | output | NUM_PINS | Pad output enable, 1 = drive |
| pad_out | output | NUM_PINS | Pad output value |
| cfg_word | output | NUM_PINS | Latched strap configuration, bit i from pad i |

## Verification
A wrong state shows up at the pads on the very next sample. A late or early LATCH shifts the rising edge of `pad_oe` by a cycle. A timer that is off by one lets `pad_out` follow its clock source one cycle early or late. A capture taken while the pads drive shows up as `cfg_word` reading the driven zeros instead of the strap. The bench sweeps all 32 strap patterns and compares every cycle of each power-up, and of each power-down, against counts derived from SYNC_STAGES and TIMER_CYCLES. So any such error is reported within the cycle in which it first appears.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_SUPPLY = 2'd0,
        ST_LATCH       = 2'd1,
        ST_DRIVE_LOW   = 2'd2,
        ST_RUN         = 2'd3
    } seq_state_e;

endpackage

// File: rtl/strap_supply_sync.sv
module strap_supply_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/strap_seq_fsm.sv
module strap_seq_fsm
    import strap_seq_pkg::*;
#(
    parameter int TIMER_CYCLES = 150000,
    localparam int CW = $clog2(TIMER_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic cap_en,
    output logic drive_en,
    output logic run_en
);

    seq_state_e state_q, state_d;
    logic [CW-1:0] tmr_q;
    logic          tmr_done;

    assign tmr_done = (tmr_q == CW'(TIMER_CYCLES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SUPPLY: if (supply_ok) state_d = ST_LATCH;
            ST_LATCH:       state_d = supply_ok ? ST_DRIVE_LOW : ST_WAIT_SUPPLY;
            ST_DRIVE_LOW: begin
                if (!supply_ok)    state_d = ST_WAIT_SUPPLY;
                else if (tmr_done) state_d = ST_RUN;
            end
            ST_RUN:         if (!supply_ok) state_d = ST_WAIT_SUPPLY;
            default:        state_d = ST_WAIT_SUPPLY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_SUPPLY;
        else        state_q <= state_d;
    end

    // power-up timer, counts only while outputs are held low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       tmr_q <= '0;
        else if (state_q != ST_DRIVE_LOW) tmr_q <= '0;
        else                              tmr_q <= tmr_q + 1'b1;
    end

    // output decode
    always_comb begin
        cap_en   = 1'b0;
        drive_en = 1'b0;
        run_en   = 1'b0;
        unique case (state_q)
            ST_WAIT_SUPPLY: ;
            ST_LATCH:       cap_en = 1'b1;
            ST_DRIVE_LOW:   drive_en = 1'b1;
            ST_RUN: begin
                drive_en = 1'b1;
                run_en   = 1'b1;
            end
            default: ;
        endcase
    end

    assert_latch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |=> (state_q != ST_LATCH));

    assert_latch_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH) |-> $past(state_q) == ST_WAIT_SUPPLY);

    assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE_LOW) |-> (tmr_q <= CW'(TIMER_CYCLES - 1)));

    assert_run_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE_LOW && supply_ok && tmr_done) |=> (state_q == ST_RUN));

    assert_no_early_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRIVE_LOW && !tmr_done) |=> (state_q != ST_RUN));

    assert_drop_to_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == ST_WAIT_SUPPLY));

endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] pad_lvl,
    output logic [WIDTH-1:0] cfg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cap_en) cfg_q <= pad_lvl;
    end

    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(cfg_q));

endmodule

// File: rtl/strap_pad_drive.sv
module strap_pad_drive #(
    parameter int WIDTH = 5
) (
    input  logic             drive_en,
    input  logic             run_en,
    input  logic [WIDTH-1:0] clk_src,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            always_comb begin
                pad_oe[i]  = drive_en;
                pad_out[i] = run_en & clk_src[i];
            end
        end
    endgenerate

endmodule

// File: rtl/strap_pad_sequencer.sv
module strap_pad_sequencer #(
    parameter int NUM_PINS     = 5,
    parameter int SYNC_STAGES  = 2,
    parameter int TIMER_CYCLES = 150000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                supply_good,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] clk_src,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] cfg_word
);

    logic supply_ok;
    logic cap_en;
    logic drive_en;
    logic run_en;

    strap_supply_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (supply_good),
        .sync_out (supply_ok)
    );

    strap_seq_fsm #(.TIMER_CYCLES(TIMER_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .cap_en    (cap_en),
        .drive_en  (drive_en),
        .run_en    (run_en)
    );

    strap_capture #(.WIDTH(NUM_PINS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .pad_lvl (pad_in),
        .cfg_q   (cfg_word)
    );

    strap_pad_drive #(.WIDTH(NUM_PINS)) u_drive (
        .drive_en (drive_en),
        .run_en   (run_en),
        .clk_src  (clk_src),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    assert_capture_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (pad_oe == '0));

    assert_quiet_when_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe == '0) |-> (pad_out == '0));

    assert_oe_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe == '0) || (pad_oe == '1));

    assert_low_before_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pad_oe[0])) |-> (pad_out == '0));

endmodule

// File: tb/strap_pad_sequencer_tb.sv
module strap_pad_sequencer_tb;

    localparam int NP = 5;
    localparam int SS = 2;
    localparam int TC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_good = 1'b0;
    logic [NP-1:0] strap = '0;
    logic [NP-1:0] clk_src = '0;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] cfg_word;
    logic [7:0]    divcnt = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // pad model: driven level wins, otherwise strap pull
    always_comb begin
        for (int i = 0; i < NP; i++)
            pad_in[i] = pad_oe[i] ? pad_out[i] : strap[i];
    end

    strap_pad_sequencer #(
        .NUM_PINS(NP), .SYNC_STAGES(SS), .TIMER_CYCLES(TC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
        .pad_in(pad_in), .clk_src(clk_src),
        .pad_oe(pad_oe), .pad_out(pad_out), .cfg_word(cfg_word)
    );

    // clock sources: pin i toggles every 2^i cycles
    initial begin
        forever begin
            @(posedge clk);
            divcnt <= divcnt + 8'd1;
            clk_src <= divcnt[NP-1:0] + 5'd1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle check of a power-up; n = edges since supply_good rose
    task automatic power_up(input logic [NP-1:0] pat, input logic [NP-1:0] old_cfg, input int cycles);
        strap = pat;
        supply_good = 1'b1;
        for (int n = 1; n <= cycles; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n == SS + 3) strap = ~pat; // R7: later strap change ignored
            if (n < SS + 2) begin
                chk(pad_oe == '0, "R2 oe released", pad_oe, '0);
                chk(pad_out == '0, "R2 out low", pad_out, '0);
                chk(cfg_word == old_cfg, "R3 no early capture", cfg_word, old_cfg);
            end else if (n < SS + 2 + TC) begin
                chk(pad_oe == '1, "R5 oe driven", pad_oe, '1);
                chk(pad_out == '0, "R5 held low", pad_out, '0);
                chk(cfg_word == pat, "R4 captured strap", cfg_word, pat);
            end else begin
                chk(pad_oe == '1, "R6 oe driven", pad_oe, '1);
                chk(pad_out == clk_src, "R6 clocks pass", pad_out, clk_src);
                chk(cfg_word == pat, "R7 cfg held", cfg_word, pat);
            end
        end
    endtask

    task automatic power_down(input logic [NP-1:0] held);
        supply_good = 1'b0;
        for (int n = 1; n <= SS + 3; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n >= SS + 1) begin
                chk(pad_oe == '0, "R8 oe off", pad_oe, '0);
                chk(pad_out == '0, "R8 out off", pad_out, '0);
            end else begin
                chk(pad_oe == '1, "R8 oe until sync", pad_oe, '1);
            end
            chk(cfg_word == held, "R7 cfg kept after drop", cfg_word, held);
        end
    endtask

    initial begin
        logic [NP-1:0] prev;
        #1;
        chk(pad_oe == '0 && pad_out == '0, "R1 reset pads", pad_oe | pad_out, '0);
        chk(cfg_word == '0, "R1 reset cfg", cfg_word, '0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pad_oe == '0 && pad_out == '0, "R1 after reset pads", pad_oe | pad_out, '0);
        chk(cfg_word == '0, "R1 after reset cfg", cfg_word, '0);

        prev = '0;
        for (int p = 0; p < (1 << NP); p++) begin
            power_up(NP'(p), prev, SS + 2 + TC + 12);
            prev = NP'(p);
            power_down(prev);
            @(negedge clk);
        end

        // R8: supply drops during DRIVE_LOW, then a fresh full sequence
        power_up(5'b10110, prev, SS + 2 + TC / 2);
        power_down(5'b10110);
        power_up(5'b01001, 5'b10110, SS + 2 + TC + 6);
        power_down(5'b01001);

        // R8: drop while in LATCH-adjacent window (single-cycle supply pulse)
        strap = 5'b11100;
        supply_good = 1'b1;
        @(negedge clk);
        supply_good = 1'b0;
        for (int n = 1; n <= SS + 4; n++) begin
            @(negedge clk);
            chk(pad_oe == '0, "R8 short pulse oe", pad_oe, '0);
        end
        chk(cfg_word == 5'b11100, "R4 short pulse capture", cfg_word, 5'b11100);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule